// File: doc/BRIEF.md
# Selectable Card Clock Divider

This block takes a reference clock of up to 27 MHz and produces the clock for a contact smart card. Two select inputs pick one of four ratios: divide by 6, 4 or 2, or pass the reference through unchanged. From a 27 MHz reference the three divide ratios give 4.5 MHz, 6.75 MHz and 13.5 MHz. For every divide ratio the output is high for exactly half the period and low for the other half, so the duty cycle is 50%. In pass-through mode the output follows the reference, so the duty cycle is whatever the reference has.

A session sequencer drives the enable input. While the enable is low, the output stays low. When the enable rises, the clock starts with a full-width first pulse. When the enable falls, the clock stops after a full-width last pulse. A new select value is taken only at the end of a low phase, so switching ratios never produces a short high or low phase. In pass-through mode the reference is gated by an enable register clocked on the falling edge of the reference, so no glitch reaches the output. A ready output is high while the clock runs.

Top module: `cardClkTop`

## Requirements
- R1: While reset is asserted and just after it is released, `cardClk` is low and `clkReady` is low.
- R2: `divSel` selects the ratio with a fixed encoding: 2'b00 divides by 6, 2'b01 divides by 4, 2'b11 divides by 2, and 2'b10 passes the reference through. In steady operation, a window of 48 reference cycles holds exactly 48/N rising output edges.
- R3: For the divide ratios, every high phase and every steady low phase lasts N/2 reference cycles. In pass-through mode each high pulse is half a reference cycle. Both select bits high (the state that pulled-up, undriven select pins give) selects divide by 2.
- R4: While `clkEn` is low, `cardClk` stays low whatever `divSel` does.
- R5: If the block is idle and `clkEn` is seen high at a rising reference edge, a divided clock rises at that same edge. A pass-through clock gives its first pulse one reference cycle later. `clkReady` rises at that edge in both cases.
- R6: When `clkEn` falls, the clock stops at the end of a low phase. The last high pulse is full width, and the output then stays low.
- R7: A change of `divSel` while the clock runs takes effect only at the end of a low phase. Every high phase has the full width of either the old ratio or the new one.
- R8: In pass-through mode the reference is gated by a register clocked on its falling edge. The pass gate and the divided phase are never active together.
- R9: `clkReady` is high exactly while the clock is running. It falls when a stop takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock, up to 27 MHz |
| rstN | input | 1 | Asynchronous reset, active low |
| divSel | input | 2 | Ratio select: 00 = /6, 01 = /4, 11 = /2, 10 = pass-through |
| clkEn | input | 1 | Clock enable from the session sequencer |
| cardClk | output | 1 | Card clock |
| clkReady | output | 1 | High while the card clock is running |

## Verification
The hardest case to reach from the ports is a select change or a stop that arrives while the output is in the middle of a high phase. The tricky transitions are between pass-through and a divide ratio, where two different paths hand the output over. Random select and enable values, each held for a random number of cycles, place these changes at every phase offset. Every high pulse is measured in half-cycle units and must match either the old ratio or the new one. Directed runs cover a start from idle, steady operation at each ratio with exact edge counts, and idle select activity.

// File: rtl/cardClkPkg.sv
package cardClkPkg;

  // width of the half-period counter; holds half ratios up to 15
  localparam int HALF_W = 4;

  // select encoding is fixed; both bits high (pulled-up pins) means /2
  typedef enum logic [1:0] {
    SEL_DIV6 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_PASS = 2'b10,
    SEL_DIV2 = 2'b11
  } ratioSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic              clear;      // force phase low, counter to zero
    logic              startHigh;  // begin a high phase this edge
    logic              passEn;     // request the pass-through gate
    logic [HALF_W-1:0] halfLen;    // reference cycles per phase
  } divStrobeT;

endpackage

// File: rtl/cardClkCtrl.sv
module cardClkCtrl
  import cardClkPkg::*;
#(
  parameter int SLOW_DIV = 6,
  parameter int MID_DIV  = 4,
  parameter int FAST_DIV = 2
) (
  input  logic      refClk,
  input  logic      rstN,
  input  logic [1:0] selIn,
  input  logic      clkEn,
  input  logic      lowEnd,
  output divStrobeT strobe,
  output logic      running
);

  localparam logic [HALF_W-1:0] HALF_SLOW = HALF_W'(SLOW_DIV / 2);
  localparam logic [HALF_W-1:0] HALF_MID  = HALF_W'(MID_DIV / 2);
  localparam logic [HALF_W-1:0] HALF_FAST = HALF_W'(FAST_DIV / 2);
  localparam logic [HALF_W-1:0] HALF_PASS = HALF_W'(1);

  ratioSelE ratioQ, ratioNext, selCode;
  logic     runQ, runNext;
  logic     boundary;
  logic     startHigh, clearPhase;

  assign selCode = ratioSelE'(selIn);

  // a period boundary: idle, pass-through, or the last cycle of a low phase
  assign boundary = !runQ || (ratioQ == SEL_PASS) || lowEnd;

  always_comb begin
    runNext    = runQ;
    ratioNext  = ratioQ;
    startHigh  = 1'b0;
    clearPhase = 1'b0;
    if (boundary) begin
      clearPhase = 1'b1;
      ratioNext  = selCode;
      if (runQ && (ratioQ == SEL_PASS) && (selCode != SEL_PASS)) begin
        // leave pass-through through one idle cycle so the gate drops first
        runNext = 1'b0;
      end else if (clkEn) begin
        runNext = 1'b1;
        if (selCode != SEL_PASS) begin
          startHigh  = 1'b1;
          clearPhase = 1'b0;
        end
      end else begin
        runNext = 1'b0;
      end
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      ratioQ <= SEL_DIV2;
    end else begin
      runQ   <= runNext;
      ratioQ <= ratioNext;
    end
  end

  always_comb begin
    unique case (ratioQ)
      SEL_DIV6: strobe.halfLen = HALF_SLOW;
      SEL_DIV4: strobe.halfLen = HALF_MID;
      SEL_DIV2: strobe.halfLen = HALF_FAST;
      default:  strobe.halfLen = HALF_PASS;
    endcase
    strobe.clear     = clearPhase;
    strobe.startHigh = startHigh;
    strobe.passEn    = runQ && (ratioQ == SEL_PASS);
  end

  assign running = runQ;

endmodule

// File: rtl/cardClkPath.sv
module cardClkPath
  import cardClkPkg::*;
(
  input  logic      refClk,
  input  logic      rstN,
  input  divStrobeT strobe,
  output logic      divHigh,
  output logic      passGate,
  output logic      lowEnd
);

  logic [HALF_W-1:0] cnt;
  logic              phaseQ;
  logic              gateQ;
  logic              lastCycle;

  assign lastCycle = (cnt == strobe.halfLen - HALF_W'(1));
  assign lowEnd    = !phaseQ && lastCycle;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
    end else if (strobe.clear) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
    end else if (strobe.startHigh) begin
      cnt    <= '0;
      phaseQ <= 1'b1;
    end else if (lastCycle) begin
      cnt    <= '0;
      phaseQ <= !phaseQ;
    end else begin
      cnt    <= cnt + HALF_W'(1);
    end
  end

  // falling-edge gate: changes only while the reference is low
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= strobe.passEn;
  end

  assign divHigh  = phaseQ;
  assign passGate = gateQ;

endmodule

// File: rtl/cardClkTop.sv
module cardClkTop
  import cardClkPkg::*;
#(
  parameter int SLOW_DIV = 6,
  parameter int MID_DIV  = 4,
  parameter int FAST_DIV = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic [1:0] divSel,
  input  logic       clkEn,
  output logic       cardClk,
  output logic       clkReady
);

  divStrobeT ctrlStrobe;
  logic      lowEnd;
  logic      divHigh;
  logic      passGate;

  cardClkCtrl #(
    .SLOW_DIV(SLOW_DIV),
    .MID_DIV (MID_DIV),
    .FAST_DIV(FAST_DIV)
  ) u_ctrl (
    .refClk (refClk),
    .rstN   (rstN),
    .selIn  (divSel),
    .clkEn  (clkEn),
    .lowEnd (lowEnd),
    .strobe (ctrlStrobe),
    .running(clkReady)
  );

  cardClkPath u_path (
    .refClk  (refClk),
    .rstN    (rstN),
    .strobe  (ctrlStrobe),
    .divHigh (divHigh),
    .passGate(passGate),
    .lowEnd  (lowEnd)
  );

  // only one source is active at a time
  assign cardClk = (refClk & passGate) | divHigh;

endmodule

// File: rtl/cardClkChk.sv
module cardClkChk
  import cardClkPkg::*;
(
  input logic              refClk,
  input logic              rstN,
  input logic              clkReady,
  input logic              divHigh,
  input logic              passGate,
  input logic [HALF_W-1:0] halfLen
);

  logic [HALF_W:0] highCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)        highCnt <= '0;
    else if (divHigh) highCnt <= highCnt + 1'b1;
    else              highCnt <= '0;
  end

  // R3
  high_width_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(divHigh) |-> (highCnt == {1'b0, halfLen}));

  // R7
  ratio_hold_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable(halfLen) |-> !$past(divHigh));

  // R8
  gate_excl_chk: assert property (@(posedge refClk) disable iff (!rstN)
    passGate |-> !divHigh);

  // R4
  idle_low_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !clkReady |-> !divHigh);

  // R6
  stop_gate_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(clkReady) |-> !passGate);

  // R9
  ready_gate_chk: assert property (@(posedge refClk) disable iff (!rstN)
    passGate |-> clkReady);

endmodule

bind cardClkTop cardClkChk u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .clkReady(clkReady),
  .divHigh (divHigh),
  .passGate(passGate),
  .halfLen (ctrlStrobe.halfLen)
);

// File: tb/test_cardClkTop.sv
module test_cardClkTop;

  logic       refClk = 1'b0;
  logic       rstN   = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic       clkEn  = 1'b0;
  logic       cardClk;
  logic       clkReady;

  int checks = 0;
  int errors = 0;

  always #4 refClk = ~refClk;

  cardClkTop i_cardClkTop (
    .refClk  (refClk),
    .rstN    (rstN),
    .divSel  (divSel),
    .clkEn   (clkEn),
    .cardClk (cardClk),
    .clkReady(clkReady)
  );

  // ratio expected from the select code (R2 encoding)
  function automatic int ratioOf(input logic [1:0] s);
    case (s)
      2'b00:   return 6;
      2'b01:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pulse tracker in half-cycle units (samples at posedge+2 and posedge+6)
  logic  lvl = 1'b0;
  int    runLen = 0;
  int    riseCnt = 0;
  int    allowA = 6;
  int    allowB = 6;
  bit    strictLow = 0;
  string runTag = "R3";

  task automatic sampleStep();
    logic v;
    v = cardClk;
    if (v === lvl) begin
      runLen++;
    end else begin
      if (lvl) begin
        checks++;
        if (runLen != allowA && runLen != allowB) begin
          errors++;
          $display("FAIL %s high width: got %0d expected %0d or %0d", runTag, runLen, allowA, allowB);
        end
      end else if (strictLow) begin
        chk({runTag, " low width"}, runLen, allowA);
      end
      if (v) riseCnt++;
      lvl    = v;
      runLen = 1;
    end
  endtask

  always begin
    @(posedge refClk);
    #2; sampleStep();
    #4; sampleStep();
  end

  task automatic drv();
    @(posedge refClk);
    #3;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) drv();
  endtask

  task automatic steadyRun(input logic [1:0] s, input string tag);
    int n, r0;
    n = ratioOf(s);
    allowA = n; allowB = n; runTag = tag;
    drv();
    divSel = s;
    clkEn  = 1'b1;
    @(posedge refClk); #2;
    // R5: start timing and ready
    chk("R5 ready at start", int'(clkReady), 1);
    if (n == 1) begin
      chk("R5 pass first cycle low", int'(cardClk), 0);
      @(posedge refClk); #2;
      chk("R5 pass first pulse", int'(cardClk), 1);
    end else begin
      chk("R5 divide rises at once", int'(cardClk), 1);
    end
    waitCyc(24);
    strictLow = 1;
    r0 = riseCnt;
    waitCyc(48);
    chk({tag, " R2 edges in 48 cycles"}, riseCnt - r0, 48 / n);
    strictLow = 0;
    clkEn = 1'b0;
    waitCyc(14);
    @(posedge refClk); #2;
    chk("R6 ready after stop", int'(clkReady), 0);
    r0 = riseCnt;
    waitCyc(10);
    chk("R6 no edges after stop", riseCnt - r0, 0);
    chk("R9 ready stays low", int'(clkReady), 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    logic [1:0] curSel;
    void'($urandom(32'd2718));

    // R1: reset state
    waitCyc(4);
    @(posedge refClk); #2;
    chk("R1 cardClk in reset", int'(cardClk), 0);
    chk("R1 ready in reset", int'(clkReady), 0);
    drv();
    rstN = 1'b1;
    waitCyc(2);
    @(posedge refClk); #2;
    chk("R1 cardClk after reset", int'(cardClk), 0);
    chk("R1 ready after reset", int'(clkReady), 0);

    // R4: select activity with enable low
    r0 = riseCnt;
    for (int i = 0; i < 30; i++) begin
      drv();
      divSel = 2'($urandom % 4);
    end
    waitCyc(2);
    chk("R4 no edges while disabled", riseCnt - r0, 0);
    chk("R4 ready while disabled", int'(clkReady), 0);

    // R2/R3/R8: steady runs at every ratio
    steadyRun(2'b00, "R3 div6");
    steadyRun(2'b01, "R3 div4");
    steadyRun(2'b11, "R3 div2 pulled-up select");
    steadyRun(2'b10, "R8 pass");

    // R7/R6: random select and enable changes at random phase offsets
    curSel = 2'b00;
    runTag = "R7";
    for (int i = 0; i < 80; i++) begin
      logic [1:0] nSel;
      logic       nEn;
      int         hold;
      nSel = 2'($urandom % 4);
      nEn  = ($urandom % 5) != 0;
      hold = 14 + int'($urandom % 40);
      allowA = ratioOf(curSel);
      allowB = ratioOf(nSel);
      drv();
      divSel = nSel;
      clkEn  = nEn;
      waitCyc(hold);
      @(posedge refClk); #2;
      if (nEn) begin
        chk("R9 ready while enabled", int'(clkReady), 1);
      end else begin
        chk("R6 ready after random stop", int'(clkReady), 0);
        chk("R4 output low after random stop", int'(cardClk), 0);
      end
      curSel = nSel;
    end

    drv();
    clkEn = 1'b0;
    waitCyc(16);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule